// File: doc/BRIEF.md
# Vector Floating-Point Trap Sequencer

This block controls the completion of a two-lane, 64-bit vector floating-point operation. An arithmetic unit outside the block computes the lanes. The block asks for lane 0 and then lane 1. After each lane it compares the lane's IEEE exception flags with the trap-enable byte of a 32-bit floating-point control register. It stops at the first lane that hits an enabled trap.

When no lane traps, the block writes the staged lane results into the 128-bit destination register in one step. In the same cycle it ORs the flags of every processed lane into the sticky byte of the control register. When a lane traps, the block changes neither register. Instead it reports an 8-bit code that holds the lane number and the highest-priority cause.

A start pulse carries a format code, a 4-bit modifier and an inexact-suppress bit. Modifier bit 3 selects single-lane mode. The block accepts the operation only for format 3 with modifier bits 2:0 all zero. Any other combination ends the operation at once with a specification error.

Top module: `vfp_trap_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `trap`, `spec_err` and `req` are low, `vxc` is 0, and `fpc` and `dst` are all zeros.
- R2: If `start` arrives with `fmt` not equal to 3, or with any of `mod[2:0]` set, then `done` and `spec_err` pulse on the next cycle with `trap` low. No lane is requested, and `dst` and `fpc` keep their values.
- R3: An accepted operation raises `req` with `req_idx` = 0. After lane 0 is consumed without a trap in two-lane mode, `req_idx` becomes 1. A lane is consumed on a cycle where `req` and `lane_vld` are both high.
- R4: With `mod[3]` = 1 (single-lane mode), only lane 0 is requested. A clean finish writes `dst[63:0]` with the lane 0 result and clears `dst[127:64]` to zero.
- R5: The flag vector is `lane_flg[4:0]`: bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact. The matching trap enables are `fpc[31:27]` in the same order. A lane traps when `lane_flg` AND `fpc[31:27]` is nonzero. The block then requests no further lane.
- R6: The cause code is the highest-priority enabled flag that was hit: invalid = 1, divide-by-zero = 2, overflow = 3, underflow = 4, inexact = 5.
- R7: On a trap, `vxc` = {3'b000, lane index, 4-bit cause}. When no trap occurs, `vxc` is 0 while `done` is high.
- R8: When `xsup` is 1 at start, an enabled inexact flag alone does not cause a trap, but it is still merged into the sticky flags.
- R9: On a trap, `dst` and `fpc` are unchanged.
- R10: On a clean finish, `fpc[23:19]` receives the OR of the flags of all processed lanes, with the same bit order as in R5. All other `fpc` bits keep their values, and `dst` = {lane 1 result, lane 0 result}.
- R11: `fpc_we` loads `fpc_wdata` into `fpc` on the next clock edge.
- R12: `done` is a one-cycle pulse that comes once for each accepted `start`. A `start` while `busy` is high is ignored. The result and `done` become visible in the cycle after the final lane is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| fmt | input | 4 | Floating-point format code; only 3 is accepted |
| mod | input | 4 | Bit 3 selects single-lane mode; bits 2:0 must be zero |
| xsup | input | 1 | Suppress traps caused by inexact alone |
| busy | output | 1 | Operation in progress |
| req | output | 1 | Lane result requested |
| req_idx | output | 1 | Index of the requested lane |
| lane_vld | input | 1 | Lane result and flags are valid |
| lane_res | input | 64 | Lane result |
| lane_flg | input | 5 | Lane exception flags (invalid, divide-by-zero, overflow, underflow, inexact) |
| fpc_we | input | 1 | Control register write enable |
| fpc_wdata | input | 32 | Control register write data |
| fpc | output | 32 | Control register |
| dst | output | 128 | Destination vector register |
| done | output | 1 | Operation finished (pulse) |
| trap | output | 1 | Operation was suppressed by a trap |
| spec_err | output | 1 | Operation was rejected by the specification check |
| vxc | output | 8 | Vector exception code |

## Verification
The assertions assume three things. First, `fpc_we` is not asserted while an operation is running, so any change to `fpc` during an operation comes from a commit. Second, `lane_vld` has meaning only while `req` is high. Third, the trap-enable byte stays stable for the whole operation. The bench stays within these limits. It writes the control register only between operations, drives `lane_vld` only on cycles where it sees `req`, and returns the lane that `req_idx` names. The one exception is a scenario that deliberately holds `start` high for the whole run.

// File: rtl/vfp_trap_ctrl.sv
module vfp_trap_ctrl #(
  parameter int EW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      fmt,
  input  logic [3:0]      mod,
  input  logic            xsup,
  output logic            busy,
  output logic            req,
  output logic            req_idx,
  input  logic            lane_vld,
  input  logic [EW-1:0]   lane_res,
  input  logic [4:0]      lane_flg,
  input  logic            fpc_we,
  input  logic [31:0]     fpc_wdata,
  output logic [31:0]     fpc,
  output logic [2*EW-1:0] dst,
  output logic            done,
  output logic            trap,
  output logic            spec_err,
  output logic [7:0]      vxc
);
  localparam logic [3:0] FMT_LONG = 4'd3;

  logic          busy_q, idx_q, single_q, xsup_q;
  logic          done_q, trap_q, spec_q;
  logic [7:0]    vxc_q;
  logic [EW-1:0] stage_q;
  logic [4:0]    acc_q;
  logic [31:0]   fpc_q;
  logic [2*EW-1:0] dst_q;

  logic [4:0] hit, flg_all;
  logic [3:0] cause;
  logic       fire, last, trap_now, commit, spec_ok;

  assign spec_ok  = (fmt == FMT_LONG) && (mod[2:0] == 3'b000);
  assign hit      = lane_flg & fpc_q[31:27] & {4'hF, ~xsup_q};
  assign fire     = busy_q & lane_vld;
  assign last     = single_q | idx_q;
  assign trap_now = fire & (|hit);
  assign commit   = fire & ~(|hit) & last;
  assign flg_all  = acc_q | lane_flg;

  always_comb begin
    if (hit[4])      cause = 4'd1;
    else if (hit[3]) cause = 4'd2;
    else if (hit[2]) cause = 4'd3;
    else if (hit[1]) cause = 4'd4;
    else if (hit[0]) cause = 4'd5;
    else             cause = 4'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; idx_q <= 1'b0; single_q <= 1'b0; xsup_q <= 1'b0;
      done_q <= 1'b0; trap_q <= 1'b0; spec_q <= 1'b0; vxc_q <= '0;
      stage_q <= '0; acc_q <= '0; dst_q <= '0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      spec_q <= 1'b0;
      vxc_q  <= '0;
      if (!busy_q && start) begin
        if (spec_ok) begin
          busy_q   <= 1'b1;
          idx_q    <= 1'b0;
          single_q <= mod[3];
          xsup_q   <= xsup;
          acc_q    <= '0;
        end else begin
          done_q <= 1'b1;
          spec_q <= 1'b1;
        end
      end
      if (fire) begin
        if (trap_now) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          trap_q <= 1'b1;
          vxc_q  <= {3'b000, idx_q, cause};
        end else if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          dst_q  <= idx_q ? {lane_res, stage_q} : {{EW{1'b0}}, lane_res};
        end else begin
          stage_q <= lane_res;
          acc_q   <= flg_all;
          idx_q   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fpc_q <= '0;
    else fpc_q <= (fpc_we ? fpc_wdata : fpc_q)
                | (commit ? {8'h00, flg_all, 19'h0} : 32'h0);
  end

  assign busy     = busy_q;
  assign req      = busy_q;
  assign req_idx  = idx_q;
  assign fpc      = fpc_q;
  assign dst      = dst_q;
  assign done     = done_q;
  assign trap     = trap_q;
  assign spec_err = spec_q;
  assign vxc      = vxc_q;
endmodule

// File: rtl/vfp_trap_ctrl_chk.sv
module vfp_trap_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req,
  input logic         req_idx,
  input logic         fpc_we,
  input logic [31:0]  fpc,
  input logic [127:0] dst,
  input logic         done,
  input logic         trap,
  input logic         spec_err,
  input logic [7:0]   vxc
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  spec_done_chk: assert property (@(posedge clk) disable iff (!rst_n) spec_err |-> done && !trap);
  // R3
  first_lane_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(req) |-> !req_idx);
  // R6
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && trap |-> (vxc[3:0] >= 4'd1) && (vxc[3:0] <= 4'd5) && (vxc[7:5] == 3'b000));
  // R7
  no_trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n) done && !trap |-> vxc == 8'h00);
  // R9
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (trap || spec_err) && !$past(fpc_we) |-> dst == $past(dst) && fpc == $past(fpc));
  // R10
  sticky_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !trap && !spec_err && !$past(fpc_we) |->
      fpc[31:24] == $past(fpc[31:24]) && fpc[18:0] == $past(fpc[18:0])
      && ((fpc[23:19] & $past(fpc[23:19])) == $past(fpc[23:19])));
endmodule

bind vfp_trap_ctrl vfp_trap_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_idx(req_idx), .fpc_we(fpc_we),
  .fpc(fpc), .dst(dst), .done(done), .trap(trap), .spec_err(spec_err), .vxc(vxc)
);

// File: tb/sim_vfp_trap_ctrl.sv
module sim_vfp_trap_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, xsup = 0, lane_vld = 0, fpc_we = 0;
  logic [3:0] fmt = 4'd3, mod = 4'd0;
  logic [63:0] lane_res = '0;
  logic [4:0] lane_flg = '0;
  logic [31:0] fpc_wdata = '0;
  logic busy, req, req_idx, done, trap, spec_err;
  logic [31:0] fpc;
  logic [127:0] dst;
  logic [7:0] vxc;
  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_fpc = '0;
  logic [127:0] exp_dst = '0;

  always #5 clk = ~clk;

  vfp_trap_ctrl u0 (.clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .mod(mod),
    .xsup(xsup), .busy(busy), .req(req), .req_idx(req_idx), .lane_vld(lane_vld),
    .lane_res(lane_res), .lane_flg(lane_flg), .fpc_we(fpc_we), .fpc_wdata(fpc_wdata),
    .fpc(fpc), .dst(dst), .done(done), .trap(trap), .spec_err(spec_err), .vxc(vxc));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_fpc(input logic [31:0] v);
    @(negedge clk); fpc_we = 1; fpc_wdata = v;
    @(negedge clk); fpc_we = 0;
    exp_fpc = v;
    chk("R11 fpc write", fpc, v);
  endtask

  task automatic run_op(input string tag, input logic [3:0] f, input logic [3:0] m,
                        input logic xs, input logic hold,
                        input logic [63:0] r0, input logic [63:0] r1,
                        input logic [4:0] g0, input logic [4:0] g1);
    int nreq, order_bad, ndone, cyc;
    logic e_trap, e_spec, got_trap, got_spec;
    logic [7:0] e_vxc, got_vxc;
    logic [4:0] acc, h;
    logic [3:0] cs;
    int nl, used;
    logic [63:0] rr [2];
    logic [4:0] gg [2];
    rr[0] = r0; rr[1] = r1; gg[0] = g0; gg[1] = g1;
    e_spec = (f != 4'd3) || (m[2:0] != 3'b000);
    e_trap = 0; e_vxc = 0; acc = 0; used = 0;
    nl = m[3] ? 1 : 2;
    if (!e_spec) begin
      for (int i = 0; i < nl; i++) begin
        used++;
        acc |= gg[i];
        h = gg[i] & exp_fpc[31:27];
        if (xs) h[0] = 1'b0;
        if (h != 0) begin
          cs = h[4] ? 4'd1 : h[3] ? 4'd2 : h[2] ? 4'd3 : h[1] ? 4'd4 : 4'd5;
          e_trap = 1; e_vxc = {3'b000, i[0], cs};
          break;
        end
      end
      if (!e_trap) begin
        exp_fpc[23:19] = exp_fpc[23:19] | acc;
        exp_dst = (nl == 1) ? {64'h0, r0} : {r1, r0};
      end
    end else used = 0;
    nreq = 0; order_bad = 0; ndone = 0; got_trap = 0; got_spec = 0; got_vxc = 0;
    @(negedge clk); start = 1; fmt = f; mod = m; xsup = xs;
    cyc = 0;
    while (cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (!hold) start = 0;
      lane_vld = 0;
      if (done) begin
        ndone++; got_trap = trap; got_spec = spec_err; got_vxc = vxc;
        start = 0;
        break;
      end
      if (req) begin
        if (req_idx != nreq[0]) order_bad++;
        lane_vld = 1; lane_res = rr[req_idx]; lane_flg = gg[req_idx];
        nreq++;
      end
    end
    lane_vld = 0;
    @(negedge clk);
    if (done) ndone++;
    chk({tag, " R12 single done"}, ndone, 1);
    chk({tag, " R3 lane order"}, order_bad, 0);
    chk({tag, " R5/R4 lanes requested"}, nreq, used);
    chk({tag, " R2 spec"}, got_spec, e_spec);
    chk({tag, " R5 trap"}, got_trap, e_trap);
    chk({tag, " R6/R7 vxc"}, got_vxc, e_vxc);
    chk({tag, " R9/R10 fpc"}, fpc, exp_fpc);
    chk({tag, " R9/R10 dst"}, dst, exp_dst);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 req", req, 0);
    chk("R1 fpc", fpc, 0); chk("R1 dst", dst, 0); chk("R1 vxc", vxc, 0);
    wr_fpc(32'h0000_0007);
    run_op("R10 clean", 4'd3, 4'd0, 0, 0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 5'h00, 5'h00);
    run_op("R10 merge", 4'd3, 4'd0, 0, 0, 64'hA, 64'hB, 5'b00001, 5'b00100);
    wr_fpc(32'hF800_0000);
    run_op("R5 lane0 invalid", 4'd3, 4'd0, 0, 0, 64'hC, 64'hD, 5'b10001, 5'b0);
    run_op("R6 lane1 ovf>unf", 4'd3, 4'd0, 0, 0, 64'hE, 64'hF, 5'b0, 5'b00110);
    run_op("R6 div>ovf", 4'd3, 4'd0, 0, 0, 64'h1, 64'h2, 5'b01100, 5'b0);
    wr_fpc(32'h1000_0000);
    run_op("R5 masked unf", 4'd3, 4'd0, 0, 0, 64'h3, 64'h4, 5'b10100, 5'b00110);
    wr_fpc(32'h0800_0000);
    run_op("R8 xsup on", 4'd3, 4'd0, 1, 0, 64'h5, 64'h6, 5'b00001, 5'b00001);
    run_op("R8 xsup off", 4'd3, 4'd0, 0, 0, 64'h7, 64'h8, 5'b0, 5'b00001);
    wr_fpc(32'h0000_0000);
    run_op("R4 single", 4'd3, 4'd8, 0, 0, 64'h99, 64'hAA, 5'b00010, 5'b10000);
    run_op("R2 bad fmt", 4'd2, 4'd0, 0, 0, 64'h1, 64'h2, 5'b0, 5'b0);
    run_op("R2 bad mod", 4'd3, 4'd1, 0, 0, 64'h1, 64'h2, 5'b0, 5'b0);
    run_op("R12 start held", 4'd3, 4'd0, 0, 1, 64'hBEEF, 64'hCAFE, 5'b0, 5'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule